// File: doc/BRIEF.md
# Dual-Tone Alert Presence Detector

This block decides whether a two-frequency alert tone is present on a telephone line. Its inputs are two hard-limited 1-bit signals. An analog front end produces them, one from a band-pass channel centred near 2130 Hz and one from a channel near 2750 Hz. The block runs from a 480 kHz clock. It measures each input's period as the number of clock cycles between successive rising edges. It marks a channel valid only while those periods stay inside a narrow window around the nominal value.

A qualification timer raises the detect output once both channels have been valid without a break for 36 ms. It drops the output again once the pair has been missing for 20 ms. An enable input masks the output without stopping the detection behind it. A host controller watches the detect pin to learn that a second call is waiting.

Top module: `tone_alert_detector`

## Requirements
- R1: While `rstN` is low, `detect` is low, both channels are invalid, the qualification timer is zero and the detector is in its waiting state.
- R2: Each input passes through two flip-flops before its rising edges are taken. A period is the number of cycles between two successive synchronized rising edges. A period is in the window when it lies within 222..228 cycles inclusive on `toneLo` (2130 Hz ±1.2%) or within 172..177 cycles inclusive on `toneHi` (2750 Hz ±1.2%).
- R3: A channel becomes valid on the second in-window period in a row. Any period outside the window clears that channel at once.
- R4: When a channel sees no synchronized rising edge for 256 cycles, it becomes invalid on that cycle. The first period measured after such a timeout counts as outside the window.
- R5: `detect` goes high exactly 17280 cycles after both channels are valid together, provided they stay valid for the whole interval.
- R6: If either channel drops out before the 17280 cycles have elapsed, the assertion timer restarts from zero. A single active tone never raises `detect`.
- R7: Once asserted, the detector stays asserted while both channels are valid. It deasserts exactly 9600 cycles after the pair stops being valid together. Both channels becoming valid again before that point restarts the release count.
- R8: `detect` is low whenever `outEn` is low. The detector keeps running while `outEn` is low, so `detect` shows the current qualified state in the same cycle that `outEn` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 480 kHz system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| outEn | input | 1 | Output enable; low forces `detect` low |
| toneLo | input | 1 | Limited output of the 2130 Hz band-pass channel |
| toneHi | input | 1 | Limited output of the 2750 Hz band-pass channel |
| detect | output | 1 | High while a qualified tone pair is present and enabled |

## Verification
A period being measured and the qualification timer reaching its limit can fall in the same cycle. The bench arranges this by stopping one tone a short time before the release count would expire, and by making a channel drop out of the window partway through an assertion count. In each case the reference model in the bench decides, cycle by cycle, whether the timer should finish or restart. The masking input is also toggled while a detection is held, so that gating and qualification overlap, and `detect` is judged against the model on every clock.

// File: rtl/tone_alert_pkg.sv
package tone_alert_pkg;

  // Strobes from the qualification control to the datapath timer
  typedef struct packed {
    logic tmrRun;      // advance the qualification timer
    logic tmrClr;      // return the timer to zero
    logic useRelease;  // compare against the release limit instead of assertion
  } qualStrobe_t;

  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_HELD = 1'b1
  } qualState_t;

endpackage

// File: rtl/tone_period_channel.sv
module tone_period_channel #(
  parameter int MIN_PER = 222,
  parameter int MAX_PER = 228,
  parameter int TIMEOUT = 256
) (
  input  logic clk,
  input  logic rstN,
  input  logic edgeIn,
  output logic valid
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] MIN_C = CW'(MIN_PER);
  localparam logic [CW-1:0] MAX_C = CW'(MAX_PER);
  localparam logic [CW-1:0] TMO_C = CW'(TIMEOUT);

  logic [CW-1:0] perCnt;
  logic [1:0]    goodRun;
  logic          inWin;

  assign inWin = (perCnt >= MIN_C) && (perCnt <= MAX_C);
  assign valid = (goodRun == 2'd2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perCnt  <= TMO_C;
      goodRun <= 2'd0;
    end else if (edgeIn) begin
      perCnt  <= CW'(1);
      goodRun <= inWin ? ((goodRun == 2'd2) ? 2'd2 : goodRun + 2'd1) : 2'd0;
    end else if (perCnt == TMO_C) begin
      goodRun <= 2'd0;
    end else begin
      perCnt <= perCnt + CW'(1);
    end
  end
endmodule

// File: rtl/tone_alert_datapath.sv
module tone_alert_datapath
  import tone_alert_pkg::*;
#(
  parameter int MIN_LO      = 222,
  parameter int MAX_LO      = 228,
  parameter int MIN_HI      = 172,
  parameter int MAX_HI      = 177,
  parameter int TIMEOUT     = 256,
  parameter int ASSERT_CYC  = 17280,
  parameter int RELEASE_CYC = 9600
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  toneIn,
  input  qualStrobe_t strobe,
  output logic [1:0]  validVec,
  output logic        tmrHit
);
  localparam int LONGEST = (ASSERT_CYC > RELEASE_CYC) ? ASSERT_CYC : RELEASE_CYC;
  localparam int TW = $clog2(LONGEST + 1);
  localparam logic [TW-1:0] ASR_LIM = TW'(ASSERT_CYC - 1);
  localparam logic [TW-1:0] REL_LIM = TW'(RELEASE_CYC - 1);

  logic [1:0] syncA, syncB, syncC;
  logic [1:0] edgeVec;
  logic [TW-1:0] qualTmr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      syncC <= '0;
    end else begin
      syncA <= toneIn;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  assign edgeVec = syncB & ~syncC;

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    tone_period_channel #(
      .MIN_PER (ch == 0 ? MIN_LO : MIN_HI),
      .MAX_PER (ch == 0 ? MAX_LO : MAX_HI),
      .TIMEOUT (TIMEOUT)
    ) i_chan (
      .clk    (clk),
      .rstN   (rstN),
      .edgeIn (edgeVec[ch]),
      .valid  (validVec[ch])
    );
  end

  assign tmrHit = (qualTmr == (strobe.useRelease ? REL_LIM : ASR_LIM));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              qualTmr <= '0;
    else if (strobe.tmrClr) qualTmr <= '0;
    else if (strobe.tmrRun) qualTmr <= qualTmr + TW'(1);
  end
endmodule

// File: rtl/tone_alert_control.sv
module tone_alert_control
  import tone_alert_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  validVec,
  input  logic        tmrHit,
  output qualStrobe_t strobe,
  output logic        detected
);
  qualState_t state, stateNxt;
  logic pairOk;

  assign pairOk   = &validVec;
  assign detected = (state == ST_HELD);

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    strobe.useRelease = (state == ST_HELD);
    // condition that keeps the current state's timer running
    if ((state == ST_WAIT) ? pairOk : !pairOk) begin
      if (tmrHit) begin
        stateNxt      = (state == ST_WAIT) ? ST_HELD : ST_WAIT;
        strobe.tmrClr = 1'b1;
      end else begin
        strobe.tmrRun = 1'b1;
      end
    end else begin
      strobe.tmrClr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_WAIT;
    else       state <= stateNxt;
  end
endmodule

// File: rtl/tone_alert_detector.sv
module tone_alert_detector
  import tone_alert_pkg::*;
#(
  parameter int MIN_LO      = 222,
  parameter int MAX_LO      = 228,
  parameter int MIN_HI      = 172,
  parameter int MAX_HI      = 177,
  parameter int TIMEOUT     = 256,
  parameter int ASSERT_CYC  = 17280,
  parameter int RELEASE_CYC = 9600
) (
  input  logic clk,
  input  logic rstN,
  input  logic outEn,
  input  logic toneLo,
  input  logic toneHi,
  output logic detect
);
  qualStrobe_t strobe;
  logic [1:0]  validVec;
  logic        tmrHit;
  logic        detected;

  tone_alert_datapath #(
    .MIN_LO(MIN_LO), .MAX_LO(MAX_LO), .MIN_HI(MIN_HI), .MAX_HI(MAX_HI),
    .TIMEOUT(TIMEOUT), .ASSERT_CYC(ASSERT_CYC), .RELEASE_CYC(RELEASE_CYC)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .toneIn   ({toneHi, toneLo}),
    .strobe   (strobe),
    .validVec (validVec),
    .tmrHit   (tmrHit)
  );

  tone_alert_control i_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .validVec (validVec),
    .tmrHit   (tmrHit),
    .strobe   (strobe),
    .detected (detected)
  );

  assign detect = detected & outEn;
endmodule

// File: rtl/tone_alert_checker.sv
module tone_alert_checker (
  input logic       clk,
  input logic       rstN,
  input logic       outEn,
  input logic       detect,
  input logic [1:0] validVec,
  input logic       detected
);
  // R8: masking input wins over any detection
  p_mask_r8: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |-> !detect);

  // R5: assertion is only reached from a cycle with both channels valid
  p_rise_needs_pair_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(detected) |-> $past(&validVec));

  // R7: release only follows a cycle where the pair was missing
  p_fall_needs_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(detected) |-> !$past(&validVec));

  // R7: a held detection survives while both channels stay valid
  p_hold_while_pair_r7: assert property (@(posedge clk) disable iff (!rstN)
    (detected && (&validVec)) |=> detected);

  // R6: without the pair the waiting state cannot be left
  p_no_rise_alone_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!detected && !(&validVec)) |=> !detected);

  // R1: reset state
  always @(posedge clk) begin
    if (!rstN) begin
      a_reset_r1: assert (!detect && !detected);
    end
  end
endmodule

bind tone_alert_detector tone_alert_checker i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .outEn    (outEn),
  .detect   (detect),
  .validVec (validVec),
  .detected (detected)
);

// File: tb/test_tone_alert_detector.sv
`timescale 1ns/1ps
module test_tone_alert_detector;
  localparam int ASR = 17280;
  localparam int REL = 9600;
  localparam int TMO = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic outEn = 1'b1;
  logic toneLo = 1'b0;
  logic toneHi = 1'b0;
  logic detect;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tone_alert_detector i_tone_alert_detector (
    .clk(clk), .rstN(rstN), .outEn(outEn),
    .toneLo(toneLo), .toneHi(toneHi), .detect(detect)
  );

  // ---------------- tone generators (drive on falling edge) ----------------
  bit onLo = 0, onHi = 0;
  int perLo = 225, perHi = 175;
  int phLo = 0, phHi = 0;

  always @(negedge clk) begin
    if (onLo) begin
      toneLo <= (phLo < perLo / 2);
      phLo   <= (phLo + 1 >= perLo) ? 0 : phLo + 1;
    end else begin
      toneLo <= 1'b0;
      phLo   <= 0;
    end
    if (onHi) begin
      toneHi <= (phHi < perHi / 2);
      phHi   <= (phHi + 1 >= perHi) ? 0 : phHi + 1;
    end else begin
      toneHi <= 1'b0;
      phHi   <= 0;
    end
  end

  // ---------------- behavioural reference model ----------------
  int mSync[2][3];
  int mCnt[2];
  int mGood[2];
  int mHeld;
  int mTmr;

  function automatic bit chanOk(int ch);
    return mGood[ch] >= 2;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rstN) begin
      for (int c = 0; c < 2; c++) begin
        for (int k = 0; k < 3; k++) mSync[c][k] = 0;
        mCnt[c]  = TMO;
        mGood[c] = 0;
      end
      mHeld = 0;
      mTmr  = 0;
    end else begin
      bit pair;
      pair = chanOk(0) && chanOk(1);
      // qualification timing on the values before this edge
      if ((mHeld == 0) == pair) begin
        if (mTmr == ((mHeld != 0) ? REL : ASR) - 1) begin
          mHeld = (mHeld != 0) ? 0 : 1;
          mTmr  = 0;
        end else begin
          mTmr++;
        end
      end else begin
        mTmr = 0;
      end
      for (int c = 0; c < 2; c++) begin
        int lo, hi;
        lo = (c == 0) ? 222 : 172;
        hi = (c == 0) ? 228 : 177;
        if (mSync[c][1] == 1 && mSync[c][2] == 0) begin
          if (mCnt[c] >= lo && mCnt[c] <= hi) mGood[c] = (mGood[c] < 2) ? mGood[c] + 1 : 2;
          else mGood[c] = 0;
          mCnt[c] = 1;
        end else if (mCnt[c] == TMO) begin
          mGood[c] = 0;
        end else begin
          mCnt[c]++;
        end
        mSync[c][2] = mSync[c][1];
        mSync[c][1] = mSync[c][0];
        mSync[c][0] = (c == 0) ? int'(toneLo) : int'(toneHi);
      end
    end
  end

  // ---------------- per-cycle comparison and edge tracking ----------------
  int riseCyc = -1, fallCyc = -1, riseCount = 0;
  logic lastDet = 1'b0;

  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic exp;
      exp = (mHeld != 0) && outEn;
      tests++;
      if (detect !== exp) begin
        fails++;
        $display("FAIL R5/R7 cycle compare at %0d: detect=%b expected=%b", cyc, detect, exp);
      end
      if (detect && !lastDet && outEn) begin riseCyc = cyc; riseCount++; end
      if (!detect && lastDet && outEn) fallCyc = cyc;
      lastDet = detect;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int t0, c0;
    waitCyc(5);
    check(detect == 1'b0, "R1 reset output", detect, 0);
    @(negedge clk) rstN = 1'b1;
    waitCyc(3);
    check(detect == 1'b0, "R1 after reset", detect, 0);

    // S1: nominal 80 ms alert, with masking while held
    perLo = 225; perHi = 175;
    t0 = cyc; onLo = 1; onHi = 1;
    while (riseCount == 0 && cyc < t0 + 30000) @(negedge clk);
    check(riseCount == 1, "R5 nominal pair detected", riseCount, 1);
    check(riseCyc - t0 >= ASR && riseCyc - t0 <= ASR + 700, "R5 assertion latency",
          riseCyc - t0, ASR);
    waitCyc(500);
    outEn = 1'b0;
    @(negedge clk);
    check(detect == 1'b0, "R8 masked output", detect, 0);
    waitCyc(200);
    outEn = 1'b1;
    #1;
    check(detect == 1'b1, "R8 unmask shows held state", detect, 1);
    while (cyc < t0 + 38400) @(negedge clk);
    onLo = 0; onHi = 0;
    c0 = cyc;
    waitCyc(REL + 900);
    check(detect == 1'b0, "R7 release after tones end", detect, 0);
    check(fallCyc - c0 >= REL && fallCyc - c0 <= REL + 800, "R7 release latency",
          fallCyc - c0, REL);
    check(fallCyc - riseCyc >= 21120, "R7 pulse width for 80 ms alert",
          fallCyc - riseCyc, 21120);

    // S2: single tone never qualifies
    riseCount = 0;
    onLo = 1;
    waitCyc(19000);
    onLo = 0;
    check(riseCount == 0, "R6 single tone", riseCount, 0);

    // S3: upper channel just outside its window
    perHi = 181;
    onLo = 1; onHi = 1;
    waitCyc(19000);
    onLo = 0; onHi = 0;
    check(riseCount == 0, "R2 out-of-window period rejected", riseCount, 0);
    waitCyc(400);

    // S4: window edges accepted; short gap does not release
    perLo = 228; perHi = 172;
    onLo = 1; onHi = 1;
    waitCyc(25000);
    check(riseCount == 1, "R2 window edges accepted", riseCount, 1);
    onHi = 0;
    waitCyc(3000);
    check(detect == 1'b1, "R7 held through short gap", detect, 1);
    onHi = 1;
    waitCyc(5000);
    check(detect == 1'b1, "R7 release count restarted", detect, 1);
    onLo = 0; onHi = 0;
    waitCyc(REL + 900);
    check(detect == 1'b0, "R7 final release", detect, 0);

    // S5: timeout dropout restarts assertion count
    perLo = 225; perHi = 175;
    riseCount = 0;
    onLo = 1; onHi = 1;
    waitCyc(6000);
    onHi = 0;
    waitCyc(400);
    t0 = cyc; onHi = 1;
    waitCyc(18500);
    check(riseCount == 1, "R4 detection after dropout", riseCount, 1);
    check(riseCyc - t0 >= ASR, "R6 assertion timer restarted", riseCyc - t0, ASR);
    onLo = 0; onHi = 0;
    waitCyc(REL + 900);
    check(detect == 1'b0, "R3 channels cleared after tones", detect, 0);

    finish_run();
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 195000);
      finish_run();
    end
  end
endmodule